// File: doc/BRIEF.md
# Phase-Shifted Carrier Gate Generator

This block drives the insertion gates of one modular multilevel converter arm. Each of its channels compares its own reference against a symmetric triangular carrier. All carriers have the same shape and the same period, and each one is delayed from its neighbour by an equal fraction of that period. A channel's gate is a plain binary pulse: it is 1 while the reference is above the carrier and 0 otherwise.

All carriers come from a single shared position counter, so the channels cannot drift apart. The counter runs from 0 to 2H-1, where H is the programmable half-period in clock cycles. Channel k adds a fixed offset to this position and folds the result into a triangle that runs 0, 1, …, H, H-1, …, 1.

Each channel takes a new reference only while its own carrier sits at zero. At all other times it holds the last value it took. Alongside the gates, the block outputs a registered count of how many channels are currently inserted.

Top module: `psc_pwm_gen`

## Requirements
- R1: While `rst_ni` is low and on the first sample after its release, every bit of `gate_o` is 0 and `on_count_o` is 0. The latched references are cleared to 0.
- R2: The shared position counter steps 0 to 2H-1 and wraps, with H taken from `half_period_i`. The carrier c of a channel is the folded position: c = p when p <= H, and c = 2H-p otherwise. Each carrier therefore changes by exactly 1 every cycle.
- R3: Channel k uses position p = (base + floor(k*2H/N_CH)) mod 2H, where base is the shared counter and base = 0 on the first edge after reset release.
- R4: A channel replaces its latched reference with its slice of `ref_i` only on an edge where its carrier is 0. At that same edge the new value is already used for the comparison. At every other edge the latched value is held.
- R5: References are 16-bit unsigned values with full scale 0x8000, which corresponds to carrier peak H. A channel's slice of `ref_i` sits at bits [16k+15:16k]. After the edge that evaluates carrier c with reference r, the gate is 1 exactly when r >= 0x8000 or r*H > c*0x8000.
- R6: A latched reference of 0 keeps the gate at 0 for every carrier value.
- R7: A latched reference of 0x8000 or more keeps the gate at 1 for every carrier value.
- R8: `on_count_o` equals the number of 1 bits in `gate_o`. Both are updated on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| half_period_i | input | 16 | Carrier half-period H in clock cycles (H >= 2) |
| ref_i | input | 160 | Per-channel references, channel k at bits [16k+15:16k] |
| gate_o | output | 10 | Gate per channel, 1 = inserted |
| on_count_o | output | 4 | Number of gates currently at 1 |

## Verification
The carrier-step and range assertions assume that `half_period_i` is at least 2 and is changed only while reset is held. The stimulus therefore sets a new half-period only inside a reset pulse. References, in contrast, are driven on the falling edge and are changed freely in the middle of a carrier period. This shows that a value arriving away from a channel's minimum has no effect until that minimum is reached.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int unsigned DEF_N_CH  = 10;
  localparam int unsigned DEF_REF_W = 16;
  localparam int unsigned DEF_CNT_W = 16;
endpackage

// File: rtl/psc_timebase.sv
module psc_timebase #(
  parameter int unsigned CNT_W = psc_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] half_i,
  output logic [CNT_W:0]   base_o
);
  localparam int unsigned PW = CNT_W + 1;

  logic [CNT_W:0] span, base_q;
  assign span   = {half_i, 1'b0};
  assign base_o = base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   base_q <= '0;
    else if (base_q >= span - PW'(1)) base_q <= '0;
    else                           base_q <= base_q + PW'(1);
  end

  a_r2_base_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_q < span);
endmodule

// File: rtl/psc_slice.sv
module psc_slice #(
  parameter int unsigned CH    = 0,
  parameter int unsigned N_CH  = psc_pkg::DEF_N_CH,
  parameter int unsigned REF_W = psc_pkg::DEF_REF_W,
  parameter int unsigned CNT_W = psc_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] half_i,
  input  logic [CNT_W:0]   base_i,
  input  logic [REF_W-1:0] ref_i,
  output logic             hit_o,
  output logic             gate_o
);
  localparam int unsigned PW     = CNT_W + 1;
  localparam int unsigned SW     = CNT_W + 2;
  localparam int unsigned OFF_W  = CNT_W + 1 + $clog2(N_CH + 1);
  localparam int unsigned PROD_W = REF_W + CNT_W;
  localparam logic [REF_W-1:0] FULL = REF_W'(1) << (REF_W - 1);

  logic [CNT_W:0]     span, off, pos;
  logic [OFF_W-1:0]   off_raw;
  logic [CNT_W+1:0]   pos_sum;
  logic [CNT_W-1:0]   car;
  logic               at_min;
  logic [REF_W-1:0]   ref_q, ref_eff;
  logic [PROD_W-1:0]  lhs, rhs;
  logic               gate_q;

  // fixed phase offset: floor(CH * 2H / N_CH)
  assign span    = {half_i, 1'b0};
  assign off_raw = (OFF_W'(CH) * OFF_W'(span)) / OFF_W'(N_CH);
  assign off     = off_raw[CNT_W:0];
  assign pos_sum = SW'(base_i) + SW'(off);
  assign pos     = (pos_sum >= SW'(span)) ? PW'(pos_sum - SW'(span)) : pos_sum[CNT_W:0];
  assign car     = (pos <= PW'(half_i)) ? pos[CNT_W-1:0] : CNT_W'(span - pos);

  assign at_min  = (car == '0);
  assign ref_eff = at_min ? ref_i : ref_q;
  assign lhs     = PROD_W'(ref_eff) * PROD_W'(half_i);
  assign rhs     = PROD_W'(car) << (REF_W - 1);
  assign hit_o   = (ref_eff >= FULL) || (lhs > rhs);
  assign gate_o  = gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      if (at_min) ref_q <= ref_i;
      gate_q <= hit_o;
    end
  end

  a_r4_ref_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_min |=> $stable(ref_q));
  a_r6_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_eff == '0) |=> !gate_q);
  a_r7_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_eff >= FULL) |=> gate_q);
  a_r2_carrier_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((PW'(car) == PW'($past(car)) + PW'(1)) || (PW'(car) + PW'(1) == PW'($past(car)))));
endmodule

// File: rtl/psc_pwm_gen.sv
module psc_pwm_gen #(
  parameter int unsigned N_CH  = psc_pkg::DEF_N_CH,
  parameter int unsigned REF_W = psc_pkg::DEF_REF_W,
  parameter int unsigned CNT_W = psc_pkg::DEF_CNT_W,
  localparam int unsigned POP_W = $clog2(N_CH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W-1:0]        half_period_i,
  input  logic [N_CH*REF_W-1:0]   ref_i,
  output logic [N_CH-1:0]         gate_o,
  output logic [POP_W-1:0]        on_count_o
);
  logic [CNT_W:0]   base;
  logic [N_CH-1:0]  hit;
  logic [POP_W-1:0] pop_d, pop_q;

  psc_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .half_i (half_period_i),
    .base_o (base)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    psc_slice #(.CH(k), .N_CH(N_CH), .REF_W(REF_W), .CNT_W(CNT_W)) u_sl (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .half_i (half_period_i),
      .base_i (base),
      .ref_i  (ref_i[k*REF_W +: REF_W]),
      .hit_o  (hit[k]),
      .gate_o (gate_o[k])
    );
  end

  always_comb begin
    pop_d = '0;
    for (int i = 0; i < N_CH; i++) pop_d = pop_d + POP_W'(hit[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pop_q <= '0;
    else         pop_q <= pop_d;
  end

  assign on_count_o = pop_q;

  a_r8_count_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(on_count_o) == $countones(gate_o));
endmodule

// File: tb/sim_psc_pwm_gen.sv
module sim_psc_pwm_gen;
  localparam int N = 10;
  localparam int RW = 16;

  logic          clk = 0;
  logic          rst_ni = 0;
  logic [15:0]   half = 16'd20;
  logic [N*RW-1:0] refs = '0;
  logic [N-1:0]  gate;
  logic [3:0]    cnt;

  int checks = 0, fails = 0, e = 0;
  bit done = 0;
  longint lat [N];
  logic [N-1:0] eg;

  always #5 clk = ~clk;

  psc_pwm_gen u0 (.clk_i(clk), .rst_ni(rst_ni), .half_period_i(half),
                  .ref_i(refs), .gate_o(gate), .on_count_o(cnt));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_ref(input int k, input int v);
    refs[k*RW +: RW] = v[15:0];
  endtask

  // R1: reset with a new half-period applied inside the pulse
  task automatic do_reset(input int h);
    @(negedge clk);
    rst_ni = 0;
    half = h[15:0];
    repeat (3) @(negedge clk);
    chk(gate == '0, "R1 gates in reset", gate, 0);
    chk(cnt == '0, "R1 count in reset", cnt, 0);
    for (int k = 0; k < N; k++) lat[k] = 0;
    e = 0;
    rst_ni = 1;
  endtask

  // one model edge per cycle, derived from R2..R5; checks at negedge (R5, R8)
  task automatic run(input int n, input string tag);
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      for (int k = 0; k < N; k++) begin
        longint h2, pos, car, r;
        h2  = 2 * longint'(half);
        pos = (longint'(e) + (longint'(k) * h2) / N) % h2;
        car = (pos <= half) ? pos : h2 - pos;
        r   = longint'(refs[k*RW +: RW]);
        if (car == 0) lat[k] = r;
        eg[k] = (lat[k] >= 32768) || (lat[k] * half > car * 32768);
      end
      e++;
      @(negedge clk);
      chk(gate == eg, tag, gate, eg);
      chk(int'(cnt) == $countones(eg), "R8 count", cnt, $countones(eg));
    end
  endtask

  task automatic t_reset_state;
    do_reset(20);
    chk(gate == '0, "R1 after release", gate, 0);
    chk(cnt == '0, "R1 count after release", cnt, 0);
  endtask

  task automatic t_zero;
    do_reset(20);
    for (int k = 0; k < N; k++) set_ref(k, 0);
    run(80, "R6 zero ref");
    chk(gate == '0, "R6 all low", gate, 0);
  endtask

  task automatic t_full;
    do_reset(20);
    for (int k = 0; k < N; k++) set_ref(k, (k % 2) ? 16'hFFFF : 16'h8000);
    run(80, "R7 full ref");
    chk(gate == '1, "R7 all high", gate, 10'h3FF);
    chk(cnt == 4'd10, "R8 full count", cnt, 10);
  endtask

  task automatic t_mid;
    do_reset(20);
    for (int k = 0; k < N; k++) set_ref(k, 16'h4000);
    run(120, "R2 R5 half duty");
  endtask

  task automatic t_stagger;
    do_reset(20);
    for (int k = 0; k < N; k++) set_ref(k, 1);
    run(80, "R3 stagger");
  endtask

  task automatic t_hold;
    do_reset(20);
    for (int k = 0; k < N; k++) set_ref(k, 16'h6000);
    for (int s = 0; s < 20; s++) begin
      run(7, "R4 latch at minimum");
      for (int k = 0; k < N; k++) set_ref(k, (s * 4099 + k * 3001) % 40000);
    end
  endtask

  task automatic t_odd_period;
    do_reset(7);
    for (int k = 0; k < N; k++) set_ref(k, k * 3500);
    run(70, "R3 odd half-period");
    do_reset(2);
    for (int k = 0; k < N; k++) set_ref(k, (k * 7000) % 36000);
    run(40, "R2 minimum half-period");
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_zero();
    t_full();
    t_mid();
    t_stagger();
    t_hold();
    t_odd_period();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule